// File: doc/BRIEF.md
# Remote DMA Port Handshake Controller

This block paces single-word transfers between a controller's local buffer memory and a host system that reaches the data through an external data latch. A remote read fetches a word from local memory, loads it into the external latch with an active-low latch write strobe, and then raises a port request. The host (or a system DMA engine) drains the latch and answers with a read acknowledge, which causes the next fetch. A remote write raises the port request first, and once the host acknowledges, it runs a local memory write cycle. A transfer counter, loaded when a command starts, ends the sequence once it reaches zero.

The port request leaves the block on one dual-purpose pin. A configuration write selects its function. With the long-address bit clear, the pin carries the port request and is always driven. With the bit set, the pin carries a one-cycle upper-address strobe at the start of every local memory cycle, and it is driven only while the bus acknowledge input is high. From reset until the first configuration write, the pin stays high-impedance. The local memory cycle is abstracted as a request/done pair. The host acknowledge is asynchronous and passes through a two-stage synchronizer followed by a rising-edge detector.

Top module: `rdma_port_hs`

## Requirements
- R1: While reset is high and in the cycle after it is released, `mem_req` is 0, `latch_wr_n` is 1 and `pin_oe` is 0.
- R2: `pin_oe` stays 0 from reset until the first `cfg_wr` pulse, including while transfers run.
- R3: After a `cfg_wr` pulse with `cfg_long`=0, `pin_oe` is 1 from the next cycle and `pin_o` carries the port request (1 = request).
- R4: After a `cfg_wr` pulse with `cfg_long`=1, `pin_oe` equals `bus_ack` delayed by one cycle, and `pin_o` pulses high for one cycle at the start of each local memory cycle.
- R5: A started read command (`cmd_write`=0) raises `mem_req` in the next cycle with `mem_we`=0, and holds it until `mem_done`.
- R6: In the cycle after `mem_done` ends a read fetch, `latch_wr_n` goes low for exactly one cycle. `lbus_data` equals the fetched `mem_rdata` word during that cycle and in the cycle after it.
- R7: After each latch load (or at a write's start), the port request is held high with no memory cycle until a rising edge of `host_ack`. That edge takes effect 3 clock edges after the change on `host_ack`. An acknowledge held high causes only one transfer step.
- R8: A started write command (`cmd_write`=1) raises the port request in the next cycle. Each acknowledge then causes one memory cycle with `mem_we`=1.
- R9: A command performs exactly `cmd_count` memory cycles. A command with `cmd_count`=0 does nothing.
- R10: The port request is low for at least one cycle between consecutive requests, so a command shows exactly `cmd_count` request rising edges.
- R11: A `cmd_go` pulse while a command is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_long | input | 1 | Long-address select bit, captured on cfg_wr |
| bus_ack | input | 1 | Bus acknowledge; enables the pin in long-address mode |
| cmd_go | input | 1 | Start a remote command |
| cmd_write | input | 1 | Command direction: 0 read, 1 write |
| cmd_count | input | CW | Number of words to transfer |
| mem_req | output | 1 | Local memory cycle request |
| mem_we | output | 1 | Local memory cycle is a write |
| mem_done | input | 1 | Local memory cycle complete (one-cycle pulse) |
| mem_rdata | input | DW | Local memory read data, valid with mem_done |
| lbus_data | output | DW | Data presented to the external latch |
| latch_wr_n | output | 1 | Active-low latch write strobe; data valid at its rising edge |
| host_ack | input | 1 | Asynchronous host acknowledge |
| pin_o | output | 1 | Dual-function pin value |
| pin_oe | output | 1 | Dual-function pin output enable (0 = high-impedance) |

## Verification
The bench sweeps both directions over transfer counts 0 to 4 and two memory latencies. It counts memory cycles, strobes and request edges, so a design that handles the counter off by one, or that treats a held acknowledge as a level, shows the wrong totals. It places each acknowledge at a known distance from the request and samples exactly three edges later. A wrong synchronizer depth, or a request that stays high across a refill, is therefore caught at a specific cycle. It also checks that the pin stays disabled before configuration and after a second reset, that a stray start pulse during a command changes nothing, and that in long-address mode the enable follows the bus acknowledge.

// File: rtl/rdma_port_pkg.sv
package rdma_port_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FETCH  = 3'd1,
    ST_STROBE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_STORE  = 3'd4
  } hs_state_e;

  function automatic logic is_mem_state(hs_state_e s);
    return (s == ST_FETCH) || (s == ST_STORE);
  endfunction

endpackage

// File: rtl/rdma_ack_sync.sv
module rdma_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic edge_o
);

  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[DEPTH-2:0], async_i};
  end

  assign edge_o = chain_q[DEPTH-2] & ~chain_q[DEPTH-1];

  // R7
  edge_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> !edge_o);

endmodule

// File: rtl/rdma_pin_mux.sv
module rdma_pin_mux (
  input  logic clk,
  input  logic rst,
  input  logic cfg_wr,
  input  logic cfg_long,
  input  logic bus_ack,
  input  logic prq,
  input  logic ads,
  output logic pin_o,
  output logic pin_oe
);

  logic seen_q, long_q, oe_q;
  logic seen_d, long_d;

  assign seen_d = cfg_wr | seen_q;
  assign long_d = cfg_wr ? cfg_long : long_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      long_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      seen_q <= seen_d;
      long_q <= long_d;
      oe_q   <= seen_d & (long_d ? bus_ack : 1'b1);
    end
  end

  assign pin_o  = long_q ? ads : prq;
  assign pin_oe = oe_q;

  // R2
  oe_needs_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> seen_q);

endmodule

// File: rtl/rdma_port_hs.sv
module rdma_port_hs
  import rdma_port_pkg::*;
#(
  parameter int CW        = 8,
  parameter int DW        = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic          cfg_long,
  input  logic          bus_ack,
  input  logic          cmd_go,
  input  logic          cmd_write,
  input  logic [CW-1:0] cmd_count,
  output logic          mem_req,
  output logic          mem_we,
  input  logic          mem_done,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] lbus_data,
  output logic          latch_wr_n,
  input  logic          host_ack,
  output logic          pin_o,
  output logic          pin_oe
);

  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  hs_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          dir_q, dir_d;
  logic [DW-1:0] data_q;
  logic          mem_req_q, mem_we_q, strb_n_q, prq_q, ads_q;
  logic          ack_edge;

  rdma_ack_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (host_ack),
    .edge_o  (ack_edge)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    dir_d   = dir_q;
    unique case (state_q)
      ST_IDLE: if (cmd_go && (cmd_count != '0)) begin
        cnt_d   = cmd_count;
        dir_d   = cmd_write;
        state_d = cmd_write ? ST_HOLD : ST_FETCH;
      end
      ST_FETCH:  if (mem_done) state_d = ST_STROBE;
      ST_STROBE: state_d = ST_HOLD;
      ST_HOLD: if (ack_edge) begin
        if (dir_q) begin
          state_d = ST_STORE;
        end else begin
          cnt_d   = cnt_q - CNT_ONE;
          state_d = (cnt_q == CNT_ONE) ? ST_IDLE : ST_FETCH;
        end
      end
      ST_STORE: if (mem_done) begin
        cnt_d   = cnt_q - CNT_ONE;
        state_d = (cnt_q == CNT_ONE) ? ST_IDLE : ST_HOLD;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      dir_q     <= 1'b0;
      data_q    <= '0;
      mem_req_q <= 1'b0;
      mem_we_q  <= 1'b0;
      strb_n_q  <= 1'b1;
      prq_q     <= 1'b0;
      ads_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      dir_q     <= dir_d;
      if (state_q == ST_FETCH && mem_done) data_q <= mem_rdata;
      mem_req_q <= is_mem_state(state_d);
      mem_we_q  <= (state_d == ST_STORE);
      strb_n_q  <= (state_d != ST_STROBE);
      prq_q     <= (state_d == ST_HOLD);
      ads_q     <= is_mem_state(state_d) && !is_mem_state(state_q);
    end
  end

  assign mem_req    = mem_req_q;
  assign mem_we     = mem_we_q;
  assign latch_wr_n = strb_n_q;
  assign lbus_data  = data_q;

  rdma_pin_mux u_pin (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_long (cfg_long),
    .bus_ack  (bus_ack),
    .prq      (prq_q),
    .ads      (ads_q),
    .pin_o    (pin_o),
    .pin_oe   (pin_oe)
  );

  // R6
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    !strb_n_q |=> strb_n_q);

  // R6
  strobe_data_chk: assert property (@(posedge clk) disable iff (rst)
    !strb_n_q |=> $stable(data_q));

  // R6
  fetch_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FETCH && mem_done) |=> !strb_n_q);

  // R7
  req_mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(prq_q && mem_req_q));

endmodule

// File: tb/rdma_port_hs_tb.sv
`timescale 1ns/100ps
module rdma_port_hs_tb;

  localparam int CW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 0, cfg_long = 0, bus_ack = 0;
  logic cmd_go = 0, cmd_write = 0;
  logic [CW-1:0] cmd_count = '0;
  logic mem_req, mem_we, mem_done;
  logic [DW-1:0] mem_rdata, lbus_data;
  logic latch_wr_n, host_ack = 0, pin_o, pin_oe;

  always #2 clk = ~clk;

  rdma_port_hs #(.CW(CW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_long(cfg_long), .bus_ack(bus_ack),
    .cmd_go(cmd_go), .cmd_write(cmd_write), .cmd_count(cmd_count),
    .mem_req(mem_req), .mem_we(mem_we), .mem_done(mem_done), .mem_rdata(mem_rdata),
    .lbus_data(lbus_data), .latch_wr_n(latch_wr_n), .host_ack(host_ack),
    .pin_o(pin_o), .pin_oe(pin_oe)
  );

  int n_chk = 0, n_fail = 0;
  int n_mem = 0, n_strb = 0, n_pin = 0;
  int lat = 0, wd_idx = 0, cyc = 0;
  logic cur_dir = 0;
  logic finished = 0;
  logic [DW-1:0] last_word = '0, strb_word = '0;
  logic prev_req = 0, prev_strb_low = 0, prev_pin = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // local memory responder
  initial begin
    int lc;
    lc = 0;
    mem_done = 0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_done = 0;
      if (mem_req) begin
        if (lc >= lat) begin
          mem_done = 1;
          last_word = DW'(16'h5A00 + wd_idx * 3);
          mem_rdata = last_word;
          wd_idx++;
          lc = 0;
        end else lc++;
      end else lc = 0;
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req && !prev_req) begin
        n_mem++;
        chk(mem_we == cur_dir, "R5/R8 mem_we at cycle start", mem_we, cur_dir);
      end
      if (!latch_wr_n) begin
        chk(!prev_strb_low, "R6 strobe width", 2, 1);
        chk(lbus_data == last_word, "R6 latch data", lbus_data, last_word);
        strb_word = lbus_data;
        n_strb++;
      end else if (prev_strb_low) begin
        chk(lbus_data == strb_word, "R6 data after strobe rise", lbus_data, strb_word);
      end
      if (pin_o && !prev_pin) n_pin++;
    end
    prev_req = mem_req;
    prev_strb_low = !latch_wr_n;
    prev_pin = pin_o;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic do_run(input logic wr, input int cnt, input int l, input bit short_mode,
                        input bit busy_go);
    int b_mem, b_strb, b_pin;
    lat = l;
    cur_dir = wr;
    b_mem = n_mem; b_strb = n_strb; b_pin = n_pin;
    cmd_write = wr;
    cmd_count = CW'(cnt);
    cmd_go = 1;
    step();
    cmd_go = 0;
    if (cnt != 0) begin
      if (wr) begin
        chk(mem_req == 0, "R8 no memory cycle before ack", mem_req, 0);
        if (short_mode) chk(pin_o == 1, "R8 request first", pin_o, 1);
      end else begin
        chk(mem_req == 1, "R5 fetch starts next cycle", mem_req, 1);
      end
    end
    for (int k = 0; k < cnt; k++) begin
      if (wr) begin
        while (mem_req) step();
      end else begin
        while (n_strb - b_strb < k + 1) step();
        step();
      end
      if (short_mode) chk(pin_o == 1, "R7 request held", pin_o, 1);
      if (busy_go && k == 0) begin
        cmd_write = ~wr;
        cmd_count = CW'(7);
        cmd_go = 1;
        step();
        cmd_go = 0;
      end
      for (int h = 0; h < 3; h++) begin
        step();
        chk(mem_req == 0, "R7 no refill before ack", mem_req, 0);
      end
      host_ack = 1;
      step(); step(); step();
      if (short_mode) chk(pin_o == 0, "R10 request drops after ack", pin_o, 0);
      if (wr || k < cnt - 1)
        chk(mem_req == 1, "R7 one step per ack edge", mem_req, 1);
      else
        chk(mem_req == 0, "R9 last ack ends command", mem_req, 0);
      for (int h = 0; h < 4; h++) step();
      host_ack = 0;
    end
    for (int h = 0; h < 12; h++) step();
    chk(n_mem - b_mem == cnt, "R9 memory cycles per command", n_mem - b_mem, cnt);
    chk(n_strb - b_strb == (wr ? 0 : cnt), "R6 strobe count", n_strb - b_strb, wr ? 0 : cnt);
    chk(n_pin - b_pin == cnt, short_mode ? "R10 request edges" : "R4 address strobe pulses",
        n_pin - b_pin, cnt);
    if (busy_go) chk(n_mem - b_mem == cnt, "R11 busy start ignored", n_mem - b_mem, cnt);
    chk(mem_req == 0 && pin_o == 0, "R9 idle after command", {mem_req, pin_o}, 0);
  endtask

  initial begin
    rst = 1;
    repeat (3) step();
    chk(mem_req == 0 && latch_wr_n == 1 && pin_oe == 0, "R1 in reset",
        {mem_req, latch_wr_n, pin_oe}, 2);
    rst = 0;
    step();
    chk(mem_req == 0 && latch_wr_n == 1 && pin_oe == 0, "R1 after reset",
        {mem_req, latch_wr_n, pin_oe}, 2);
    do_run(1'b0, 1, 0, 1'b1, 1'b0);
    chk(pin_oe == 0, "R2 unconfigured pin stays high-Z", pin_oe, 0);
    cfg_long = 0;
    cfg_wr = 1;
    step();
    cfg_wr = 0;
    chk(pin_oe == 1, "R3 short mode drives pin", pin_oe, 1);
    for (int d = 0; d < 2; d++)
      for (int c = 0; c < 5; c++)
        for (int li = 0; li < 2; li++)
          do_run(d[0], c, li * 2, 1'b1, 1'b0);
    do_run(1'b0, 2, 1, 1'b1, 1'b1);
    do_run(1'b1, 2, 1, 1'b1, 1'b1);
    bus_ack = 0;
    cfg_long = 1;
    cfg_wr = 1;
    step();
    cfg_wr = 0;
    chk(pin_oe == 0, "R4 long mode without bus ack", pin_oe, 0);
    bus_ack = 1;
    chk(pin_oe == 0, "R4 enable one cycle late", pin_oe, 0);
    step();
    chk(pin_oe == 1, "R4 long mode with bus ack", pin_oe, 1);
    do_run(1'b0, 3, 1, 1'b0, 1'b0);
    do_run(1'b1, 3, 1, 1'b0, 1'b0);
    bus_ack = 0;
    step();
    chk(pin_oe == 0, "R4 bus ack released", pin_oe, 0);
    bus_ack = 1;
    rst = 1;
    step();
    rst = 0;
    step(); step();
    chk(pin_oe == 0, "R2 high-Z again after reset", pin_oe, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule